// File: doc/BRIEF.md
# Switch Input Debouncer with Event Filtering

This block cleans up eight slow switch inputs of a vehicle lamp controller: the turn levers, the hazard switch, a cancel contact, the engine and brake switches, and two qualifier contacts. These last two tell whether the steering wheel is turning back against the signalled direction, or whether the driver pressed the cancel contact by hand. All inputs are sampled together, but only on clock cycles where the slow sample tick is high. An input's clean level changes only after three samples in a row agree.

Next to the clean level vector, the block gives a change-event vector. Each event lasts one clock cycle and follows the tick that moved the level. The lamp logic downstream uses these events as commands. The policy differs by bit:
- The levers, hazard and cancel bits report only presses.
- Engine and brake report both edges.
- The qualifier bits never report.
- A cancel press is dropped unless one of the qualifiers is active in the clean state, which screens out wheel rotation in the same direction as the signal.

Bit map, used on `raw_i`, `state_o` and `event_o`:

| Bit | Input |
|-----|-------|
| 0 | left lever |
| 1 | right lever |
| 2 | hazard (the raw pin is active-low) |
| 3 | cancel |
| 4 | engine |
| 5 | brake |
| 6 | opposite-rotation qualifier |
| 7 | manual qualifier |

Top module: `switch_debouncer`

## Requirements
- R1: While `rst_ni` is low, and right after it is released, `state_o` and `event_o` are 0, and the sample history is all zero.
- R2: Raw bit 2 (hazard) is active-low. It is inverted before debouncing, so a held raw 0 gives `state_o[2]`=1. Every other raw bit is taken as is.
- R3: A bit of `state_o` takes a new value only if the sample on the current tick and the samples on the two ticks before it are all equal. A pulse seen on fewer than three consecutive ticks leaves the state as it was.
- R4: An input that changes before tick k and stays put shows in `state_o` after the clock edge of tick k+2, and not before.
- R5: The bits are debounced in parallel and independently. Several bits that move together all update on the same tick.
- R6: Bits 0–3 raise an event only when their clean level goes from 0 to 1. Releases raise nothing.
- R7: Bits 4 and 5 raise an event on every change of their clean level, in either direction.
- R8: Bits 6 and 7 are debounced into `state_o`, but `event_o[7:6]` is always 0.
- R9: A cancel event (`event_o[3]`) is raised only if bit 6 or bit 7 of the updated clean state is 1. Otherwise the event is suppressed.
- R10: `event_o` is nonzero only in the clock cycle right after a tick edge, so each event lasts exactly one cycle.
- R11: Without a tick, changes on `raw_i` have no effect on `state_o` or on the history.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| tick_i | input | 1 | sample enable, one cycle per slow tick |
| raw_i | input | 8 | raw switch levels (bit 2 active-low) |
| state_o | output | 8 | debounced levels, active-high |
| event_o | output | 8 | one-cycle change events |

## Verification
The bench targets the following corner cases, each paired with the failure it would expose:

- **Two-tick glitch.** A short debounce window would latch this glitch.
- **Third-tick update.** A window that is off by one shows the new level one tick early or one tick late.
- **Release of a press-only input.** A missing edge filter raises a spurious command on release.
- **Engine falling edge.** A design that filters every bit the same way misses this event.
- **Qualifier bits.** These must set the state but raise no event.
- **Cancel in both qualifier contexts.** Swapped gating raises a cancel on same-direction rotation, or drops a real one.
- **Hazard polarity.** A missing inversion shows the hazard as permanently on.
- **Raw changes between ticks.** A free-running sampler would let these leak into the state.

A behavioural model then tracks the design on every clock while the inputs and the tick spacing are randomised.

// File: rtl/debounce_pkg.sv
package debounce_pkg;
  localparam int unsigned NUM_IN   = 8;
  localparam int unsigned IDX_LEFT = 0;
  localparam int unsigned IDX_RGHT = 1;
  localparam int unsigned IDX_HAZ  = 2;
  localparam int unsigned IDX_CAN  = 3;
  localparam int unsigned IDX_ENG  = 4;
  localparam int unsigned IDX_BRK  = 5;
  localparam int unsigned IDX_OPP  = 6;
  localparam int unsigned IDX_MAN  = 7;

  localparam logic [NUM_IN-1:0] INV_MASK   = NUM_IN'(1) << IDX_HAZ;
  localparam logic [NUM_IN-1:0] PRESS_MASK = (NUM_IN'(1) << IDX_LEFT) | (NUM_IN'(1) << IDX_RGHT)
                                           | (NUM_IN'(1) << IDX_HAZ)  | (NUM_IN'(1) << IDX_CAN);
  localparam logic [NUM_IN-1:0] BOTH_MASK  = (NUM_IN'(1) << IDX_ENG) | (NUM_IN'(1) << IDX_BRK);

  typedef enum logic [1:0] {
    POL_NONE  = 2'd0,
    POL_PRESS = 2'd1,
    POL_BOTH  = 2'd2
  } edge_pol_e;

  function automatic edge_pol_e pol_of(input int unsigned b);
    if (PRESS_MASK[b])     return POL_PRESS;
    else if (BOTH_MASK[b]) return POL_BOTH;
    else                   return POL_NONE;
  endfunction
endpackage

// File: rtl/dbc_history.sv
module dbc_history #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic [W-1:0] smp_i,
  output logic [W-1:0] stable_o
);
  localparam int unsigned NREG = DEPTH - 1;

  logic [W-1:0] hist_q [NREG];
  logic [W-1:0] agree  [NREG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) hist_q[i] <= '0;
    end else if (tick_i) begin
      hist_q[0] <= smp_i;
      for (int i = 1; i < NREG; i++) hist_q[i] <= hist_q[i-1];
    end
  end

  // every stored sample must equal the fresh one
  for (genvar g = 0; g < NREG; g++) begin : g_cmp
    if (g == 0) begin : g_first
      assign agree[g] = ~(smp_i ^ hist_q[g]);
    end else begin : g_rest
      assign agree[g] = agree[g-1] & ~(smp_i ^ hist_q[g]);
    end
  end

  assign stable_o = agree[NREG-1];
endmodule

// File: rtl/dbc_state.sv
module dbc_state #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic [W-1:0] smp_i,
  input  logic [W-1:0] stable_i,
  output logic [W-1:0] state_o,
  output logic [W-1:0] nxt_o
);
  logic [W-1:0] state_q;

  assign nxt_o = (state_q & ~stable_i) | (smp_i & stable_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     state_q <= '0;
    else if (tick_i) state_q <= nxt_o;
  end

  assign state_o = state_q;
endmodule

// File: rtl/dbc_event.sv
module dbc_event
  import debounce_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [NUM_IN-1:0] cur_i,
  input  logic [NUM_IN-1:0] nxt_i,
  output logic [NUM_IN-1:0] event_o
);
  logic [NUM_IN-1:0] raise;
  logic              can_ok;

  assign can_ok = nxt_i[IDX_OPP] | nxt_i[IDX_MAN];

  for (genvar g = 0; g < NUM_IN; g++) begin : g_bit
    localparam edge_pol_e POL = pol_of(g);
    if (POL == POL_PRESS && g == IDX_CAN) begin : g_can
      assign raise[g] = nxt_i[g] & ~cur_i[g] & can_ok;
    end else if (POL == POL_PRESS) begin : g_press
      assign raise[g] = nxt_i[g] & ~cur_i[g];
    end else if (POL == POL_BOTH) begin : g_both
      assign raise[g] = nxt_i[g] ^ cur_i[g];
    end else begin : g_none
      assign raise[g] = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     event_o <= '0;
    else if (tick_i) event_o <= raise;
    else             event_o <= '0;
  end
endmodule

// File: rtl/switch_debouncer.sv
module switch_debouncer
  import debounce_pkg::*;
#(
  parameter int unsigned DEPTH = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [NUM_IN-1:0] raw_i,
  output logic [NUM_IN-1:0] state_o,
  output logic [NUM_IN-1:0] event_o
);
  logic [NUM_IN-1:0] smp;
  logic [NUM_IN-1:0] stable;
  logic [NUM_IN-1:0] nxt;

  assign smp = raw_i ^ INV_MASK;

  dbc_history #(.W(NUM_IN), .DEPTH(DEPTH)) i_hist (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .smp_i    (smp),
    .stable_o (stable)
  );

  dbc_state #(.W(NUM_IN)) i_state (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .smp_i    (smp),
    .stable_i (stable),
    .state_o  (state_o),
    .nxt_o    (nxt)
  );

  dbc_event i_evt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .cur_i   (state_o),
    .nxt_i   (nxt),
    .event_o (event_o)
  );
endmodule

// File: rtl/switch_debouncer_chk.sv
module switch_debouncer_chk
  import debounce_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic [NUM_IN-1:0] state_o,
  input logic [NUM_IN-1:0] event_o
);
  AST_EVT_AFTER_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (event_o != '0) |-> $past(tick_i)); // R10
  AST_STATE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(tick_i) |-> $stable(state_o)); // R11
  AST_PRESS_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (event_o & PRESS_MASK & ~state_o) == '0); // R6
  AST_AUX_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !event_o[IDX_OPP] && !event_o[IDX_MAN]); // R8
  AST_CAN_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    event_o[IDX_CAN] |-> (state_o[IDX_OPP] || state_o[IDX_MAN])); // R9
  AST_ENG_CHANGED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    event_o[IDX_ENG] |-> (state_o[IDX_ENG] != $past(state_o[IDX_ENG]))); // R7
endmodule

bind switch_debouncer switch_debouncer_chk i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .tick_i  (tick_i),
  .state_o (state_o),
  .event_o (event_o)
);

// File: tb/test_switch_debouncer.sv
module test_switch_debouncer;
  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [7:0] raw = 8'h04;
  logic [7:0] state, evt;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  switch_debouncer i_switch_debouncer (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .tick_i  (tick),
    .raw_i   (raw),
    .state_o (state),
    .event_o (evt)
  );

  // behavioural reference
  logic [7:0] smp_q[$];
  logic [7:0] exp_state = 8'h00;
  logic [7:0] exp_evt = 8'h00;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_q = '{8'h00, 8'h00};
      exp_state = 8'h00;
      exp_evt = 8'h00;
    end else if (tick) begin
      logic [7:0] s, ns, ev;
      s = raw ^ 8'h04;
      ns = exp_state;
      for (int b = 0; b < 8; b++)
        if (s[b] == smp_q[0][b] && s[b] == smp_q[1][b]) ns[b] = s[b];
      ev = 8'h00;
      for (int b = 0; b < 4; b++) if (ns[b] && !exp_state[b]) ev[b] = 1'b1;
      for (int b = 4; b < 6; b++) if (ns[b] != exp_state[b]) ev[b] = 1'b1;
      if (!ns[6] && !ns[7]) ev[3] = 1'b0;
      smp_q.push_front(s);
      void'(smp_q.pop_back());
      exp_state = ns;
      exp_evt = ev;
    end else begin
      exp_evt = 8'h00;
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk("R5 model state", state, exp_state);
    chk("R10 model event", evt, exp_evt);
  end

  task automatic do_tick();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) do_tick();
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset state", state, 8'h00);
    chk("R1 reset event", evt, 8'h00);
    rst_n = 1'b1;
    ticks(3);
    chk("R1 idle state", state, 8'h00);

    raw = 8'h05; ticks(2);
    chk("R4 left early", state, 8'h00);
    do_tick();
    chk("R4 left third tick", state, 8'h01);
    chk("R6 left press event", evt, 8'h01);
    @(negedge clk);
    chk("R10 pulse one cycle", evt, 8'h00);
    raw = 8'h04; ticks(3);
    chk("R6 release state", state, 8'h00);
    chk("R6 release no event", evt, 8'h00);

    raw = 8'h14; ticks(2); raw = 8'h04; ticks(3);
    chk("R3 glitch state", state, 8'h00);
    chk("R3 glitch event", evt, 8'h00);

    raw = 8'h14; ticks(3);
    chk("R7 engine rise state", state, 8'h10);
    chk("R7 engine rise event", evt, 8'h10);
    raw = 8'h04; ticks(3);
    chk("R7 engine fall state", state, 8'h00);
    chk("R7 engine fall event", evt, 8'h10);

    raw = 8'h00; ticks(3);
    chk("R2 hazard state", state, 8'h04);
    chk("R2 hazard event", evt, 8'h04);
    raw = 8'h04; ticks(3);
    chk("R2 hazard off", state, 8'h00);

    raw = 8'hA1; repeat (12) @(negedge clk);
    chk("R11 no tick state", state, 8'h00);
    chk("R11 no tick event", evt, 8'h00);
    raw = 8'h04; ticks(3);
    chk("R11 history untouched", state, 8'h00);

    raw = 8'h0C; ticks(3);
    chk("R9 cancel state", state, 8'h08);
    chk("R9 cancel suppressed", evt, 8'h00);
    raw = 8'h04; ticks(3);
    raw = 8'h44; ticks(3);
    chk("R8 opp state", state, 8'h40);
    chk("R8 opp no event", evt, 8'h00);
    raw = 8'h4C; ticks(3);
    chk("R9 cancel qualified state", state, 8'h48);
    chk("R9 cancel qualified event", evt, 8'h08);
    raw = 8'h04; ticks(3);
    chk("R8 release quiet", evt, 8'h00);

    raw = 8'hA5; ticks(3);
    chk("R5 parallel state", state, 8'hA1);
    chk("R5 parallel event", evt, 8'h21);
    raw = 8'h04; ticks(3);
    chk("R5 parallel release", state, 8'h00);
    chk("R7 brake fall event", evt, 8'h20);

    for (int n = 0; n < 800; n++) begin
      @(negedge clk);
      tick = ($urandom_range(0, 2) == 0);
      if ($urandom_range(0, 5) == 0) raw[$urandom_range(0, 7)] ^= 1'b1;
    end
    @(negedge clk) tick = 1'b0;
    @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule